// File: doc/BRIEF.md
# RGB to Composite Video Encoder

The block turns a stream of 64-colour pixels (two bits each of red, green and blue) and a sync flag into a 7-bit code for a resistor-ladder DAC that produces a composite baseband signal. A computed 64-entry constant table gives each colour a signed luma value and two signed colour-difference values. The two colour-difference values are modulated by two square-wave carriers, one in phase and one in quadrature, that a separate oscillator supplies as single bits. Luma, the two modulated terms and a fixed black pedestal are added and clamped into the ladder's code range. During sync the code is forced to zero.

Multiplying by a ±1 square wave reduces to keeping or negating a term, so the chroma path needs no multiplier. One parameter picks the colour-difference gains for the 625-line or the 525-line standard. A second parameter sets how far the chroma products are shifted down, and so the colour saturation. The output is registered, and every input reaches it two clocks after it is sampled.

Top module: `cvbs_encoder`

## Requirements
- R1: While rstN is low, and at the first clock edge after reset is released, dacCode is 0.
- R2: pixelRgb, syncIn, carrierI and carrierQ are sampled at the same clock edge, and their effect appears on dacCode after exactly two rising edges, with one new result every cycle.
- R3: When syncIn is 1, dacCode is 0 two cycles later, whatever the pixel and carrier values are.
- R4: pixelRgb is {r[1:0], g[1:0], b[1:0]} with bits 5:4 red. Luma is Y = floor((10r + 19g + 3b) / 3), which lies in the range 0..32.
- R5: Let Bl = floor(32b/3) and Rl = floor(32r/3). Then U = ((Bl − Y)·KU) >>> CHROMA_SHIFT and V = ((Rl − Y)·KV) >>> CHROMA_SHIFT, where >>> is an arithmetic (floor) shift.
- R6: When syncIn is 0, the code is 16 + Y + sU·U + sV·V, where sU is +1 if carrierI is 1 and −1 if it is 0, and sV follows carrierQ in the same way.
- R7: A grey pixel (r = g = b) gives the same code for every carrier state. Black (all zero) gives 16, white (all ones) gives 48, and the greys with levels 1 and 2 give 26 and 37.
- R8: A sum below 0 is output as 0 and a sum above 127 as 127, so the code never wraps.
- R9: When PAL_MODE is 0, the gains are KU = 7 and KV = 10. When PAL_MODE is 1, they are KU = 8 and KV = 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixelRgb | input | 6 | Pixel colour {r, g, b}, two bits per channel |
| syncIn | input | 1 | Sync interval, forces the output to the sync level |
| carrierI | input | 1 | In-phase colour carrier square wave |
| carrierQ | input | 1 | Quadrature colour carrier square wave |
| dacCode | output | 7 | Code for the resistor-ladder DAC |

## Verification
With the default saturation the clamp is never reached: the most extreme colour stays well inside 0..127. The bench therefore builds a second instance with CHROMA_SHIFT set to 1 and drives magenta into it with both carriers high and then both low, which pushes the sum past 127 and below 0. A third instance with PAL_MODE set to 1 runs on the same stimulus, which exposes the gain selection. All 256 combinations of colour and carrier state are streamed back to back, with sync mixed in, so a wrong pipeline depth or a misaligned sync stage shows up as a mismatch.

// File: rtl/cvbs_pkg.sv
package cvbs_pkg;

  typedef struct packed {
    logic blank;
    logic posU;
    logic posV;
  } strobe_t;

  function automatic int chanOf(int idx, int pos);
    return (idx >> pos) & 3;
  endfunction

  function automatic int lumaOf(int idx);
    return (10 * chanOf(idx, 4) + 19 * chanOf(idx, 2) + 3 * chanOf(idx, 0)) / 3;
  endfunction

  function automatic int diffOf(int level, int luma, int gain, int shift);
    int prod;
    prod = ((32 * level) / 3 - luma) * gain;
    return prod >>> shift;
  endfunction

endpackage

// File: rtl/cvbs_ctrl.sv
module cvbs_ctrl
  import cvbs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    syncIn,
  input  logic    carrierI,
  input  logic    carrierQ,
  output strobe_t ctrlStb
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlStb <= '{blank: 1'b1, posU: 1'b0, posV: 1'b0};
    end else begin
      ctrlStb.blank <= syncIn;
      ctrlStb.posU  <= carrierI;
      ctrlStb.posV  <= carrierQ;
    end
  end

endmodule

// File: rtl/cvbs_datapath.sv
module cvbs_datapath
  import cvbs_pkg::*;
#(
  parameter bit PAL_MODE     = 1'b0,
  parameter int CHROMA_SHIFT = 4,
  parameter int CODE_W       = 7,
  parameter int TERM_W       = 10,
  parameter int BLACK_LEVEL  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        pixelRgb,
  input  strobe_t           ctrlStb,
  output logic [CODE_W-1:0] dacCode
);

  localparam int GAIN_U   = PAL_MODE ? 8 : 7;
  localparam int GAIN_V   = PAL_MODE ? 11 : 10;
  localparam int SUM_W    = TERM_W + 3;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int ENTRIES  = 64;

  logic signed [TERM_W-1:0] lutY [ENTRIES];
  logic signed [TERM_W-1:0] lutU [ENTRIES];
  logic signed [TERM_W-1:0] lutV [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_lut
    localparam int Y_I = lumaOf(i);
    localparam int U_I = diffOf(chanOf(i, 0), Y_I, GAIN_U, CHROMA_SHIFT);
    localparam int V_I = diffOf(chanOf(i, 4), Y_I, GAIN_V, CHROMA_SHIFT);
    assign lutY[i] = TERM_W'(Y_I);
    assign lutU[i] = TERM_W'(U_I);
    assign lutV[i] = TERM_W'(V_I);
  end

  logic signed [TERM_W-1:0] yReg, uReg, vReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yReg <= '0;
      uReg <= '0;
      vReg <= '0;
    end else begin
      yReg <= lutY[pixelRgb];
      uReg <= lutU[pixelRgb];
      vReg <= lutV[pixelRgb];
    end
  end

  logic signed [SUM_W-1:0] uTerm, vTerm, sum;
  logic [CODE_W-1:0] codeNext;

  always_comb begin
    uTerm = ctrlStb.posU ? SUM_W'(uReg) : -SUM_W'(uReg);
    vTerm = ctrlStb.posV ? SUM_W'(vReg) : -SUM_W'(vReg);
    sum   = SUM_W'(BLACK_LEVEL) + SUM_W'(yReg) + uTerm + vTerm;
    if (sum < 0)
      codeNext = '0;
    else if (sum > SUM_W'(CODE_MAX))
      codeNext = CODE_W'(CODE_MAX);
    else
      codeNext = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      dacCode <= '0;
    else if (ctrlStb.blank)
      dacCode <= '0;
    else
      dacCode <= codeNext;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) !rstN |=> dacCode == '0); // R1

  AST_SYNC_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.blank |=> dacCode == '0); // R3

endmodule

// File: rtl/cvbs_encoder.sv
module cvbs_encoder
  import cvbs_pkg::*;
#(
  parameter bit PAL_MODE     = 1'b0,
  parameter int CHROMA_SHIFT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] pixelRgb,
  input  logic       syncIn,
  input  logic       carrierI,
  input  logic       carrierQ,
  output logic [6:0] dacCode
);

  strobe_t ctrlStb;

  cvbs_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .carrierI(carrierI),
    .carrierQ(carrierQ),
    .ctrlStb (ctrlStb)
  );

  cvbs_datapath #(
    .PAL_MODE    (PAL_MODE),
    .CHROMA_SHIFT(CHROMA_SHIFT),
    .CODE_W      (7)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pixelRgb(pixelRgb),
    .ctrlStb (ctrlStb),
    .dacCode (dacCode)
  );

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |-> ##2 dacCode == 7'd0); // R2

  AST_GREY_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (!syncIn && pixelRgb[5:4] == pixelRgb[3:2] && pixelRgb[3:2] == pixelRgb[1:0])
    |-> ##2 dacCode == 7'(16 + (32 * int'($past(pixelRgb[5:4], 2))) / 3)); // R7

endmodule

// File: tb/cvbs_encoder_test.sv
`timescale 1ns/1ps
module cvbs_encoder_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] pixelRgb = '0;
  logic syncIn = 1'b0, carrierI = 1'b0, carrierQ = 1'b0;
  logic [6:0] codeNtsc, codePal, codeHot;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cvbs_encoder #(.PAL_MODE(1'b0), .CHROMA_SHIFT(4)) uut (
    .clk(clk), .rstN(rstN), .pixelRgb(pixelRgb), .syncIn(syncIn),
    .carrierI(carrierI), .carrierQ(carrierQ), .dacCode(codeNtsc));
  cvbs_encoder #(.PAL_MODE(1'b1), .CHROMA_SHIFT(4)) uutPal (
    .clk(clk), .rstN(rstN), .pixelRgb(pixelRgb), .syncIn(syncIn),
    .carrierI(carrierI), .carrierQ(carrierQ), .dacCode(codePal));
  cvbs_encoder #(.PAL_MODE(1'b0), .CHROMA_SHIFT(1)) uutHot (
    .clk(clk), .rstN(rstN), .pixelRgb(pixelRgb), .syncIn(syncIn),
    .carrierI(carrierI), .carrierQ(carrierQ), .dacCode(codeHot));

  // {rgb[5:0], sync, carrierI, carrierQ}
  localparam logic [8:0] VECS [12] = '{
    {6'b110000, 3'b011}, {6'b110000, 3'b000}, {6'b001100, 3'b010},
    {6'b000011, 3'b001}, {6'b111100, 3'b011}, {6'b001111, 3'b000},
    {6'b110011, 3'b010}, {6'b011001, 3'b001}, {6'b100110, 3'b011},
    {6'b010101, 3'b000}, {6'b111111, 3'b111}, {6'b000011, 3'b100}
  };

  function automatic int model(int rgb, bit s, bit ci, bit cq, bit pal, int sh);
    int r, g, b, y, u, v, t;
    if (s) return 0;
    r = (rgb >> 4) & 3; g = (rgb >> 2) & 3; b = rgb & 3;
    y = (10 * r + 19 * g + 3 * b) / 3;
    u = (((32 * b) / 3 - y) * (pal ? 8 : 7)) >>> sh;
    v = (((32 * r) / 3 - y) * (pal ? 11 : 10)) >>> sh;
    t = 16 + y + (ci ? u : -u) + (cq ? v : -v);
    if (t < 0) t = 0;
    if (t > 127) t = 127;
    return t;
  endfunction

  task automatic check(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkAll(int rgb, bit s, bit ci, bit cq, string req);
    check(int'(codeNtsc), model(rgb, s, ci, cq, 1'b0, 4), req);
    check(int'(codePal), model(rgb, s, ci, cq, 1'b1, 4), "R9");
    check(int'(codeHot), model(rgb, s, ci, cq, 1'b0, 1), "R8");
  endtask

  task automatic drive(int rgb, bit s, bit ci, bit cq);
    pixelRgb = 6'(rgb); syncIn = s; carrierI = ci; carrierQ = cq;
  endtask

  task automatic applyWait(int rgb, bit s, bit ci, bit cq);
    @(negedge clk);
    drive(rgb, s, ci, cq);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state with a bright chroma pixel on the inputs
    drive(6'b110011, 1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check(int'(codeNtsc), 0, "R1");
    check(int'(codeHot), 0, "R1");
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(int'(codeNtsc), 0, "R1");

    // table of vectors
    foreach (VECS[i]) begin
      applyWait(int'(VECS[i][8:3]), VECS[i][2], VECS[i][1], VECS[i][0]);
      checkAll(int'(VECS[i][8:3]), VECS[i][2], VECS[i][1], VECS[i][0], "R5");
    end

    // Y isolation through greys, every carrier state
    for (int c = 0; c < 4; c++) begin
      applyWait(6'b000000, 1'b0, c[1], c[0]); check(int'(codeNtsc), 16, "R7");
      applyWait(6'b111111, 1'b0, c[1], c[0]); check(int'(codeNtsc), 48, "R7");
      applyWait(6'b010101, 1'b0, c[1], c[0]); check(int'(codeNtsc), 26, "R4");
      applyWait(6'b101010, 1'b0, c[1], c[0]); check(int'(codeHot), 37, "R4");
    end

    // saturation on the high-gain instance with magenta
    applyWait(6'b110011, 1'b0, 1'b1, 1'b1); check(int'(codeHot), 127, "R8");
    applyWait(6'b110011, 1'b0, 1'b0, 1'b0); check(int'(codeHot), 0, "R8");

    // sync overrides white
    applyWait(6'b111111, 1'b1, 1'b1, 1'b1);
    check(int'(codeNtsc), 0, "R3");
    check(int'(codeHot), 0, "R3");

    // streamed sweep: every colour and carrier state, sync mixed in
    begin
      int hist [2];
      hist[0] = -1; hist[1] = -1;
      for (int k = 0; k < 258; k++) begin
        @(negedge clk);
        if (hist[1] >= 0) begin
          int h;
          h = hist[1];
          checkAll(h & 63, ((h >> 8) & 1) == 1, ((h >> 7) & 1) == 1,
                   ((h >> 6) & 1) == 1, "R6");
          if (((h >> 8) & 1) == 1) check(int'(codeNtsc), 0, "R2");
        end
        hist[1] = hist[0];
        if (k < 256) begin
          int s;
          s = (k % 17 == 5) ? 1 : 0;
          hist[0] = (s << 8) | k;
          drive(k & 63, s == 1, ((k >> 7) & 1) == 1, ((k >> 6) & 1) == 1);
        end else begin
          hist[0] = -1;
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule